// File: doc/BRIEF.md
# Command Decode and Sync Stall Controller

This block sits at the read side of a command buffer and inspects the word at its head. It classifies the word by its opcode, decides whether the word may leave the buffer, and registers each accepted word. From that registered copy it drives two outputs:

- a one-cycle start pulse and the primitive payload for the edge-walker data bus;
- an attribute strobe with the texture data, tile address and a one-hot register write enable.

Sync commands put the front end into a stall. While stalled, the read side of the buffer is frozen and no start pulse or attribute strobe can appear. The stall ends only when a release arrives whose tag names the pending sync type.

The buffer side is a valid/ready stream. A word moves on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` depends on the opcode of the presented word, so the buffer must hold `in_data` stable while `in_valid` is high and no transfer has taken place. The downstream sides have no back-pressure apart from `ew_busy_i`, which holds a primitive at the head of the buffer. The outputs are strobes that last one cycle. The release input and the stall output are plain control pins.

Top module: `cmdsync_ctrl`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `stall_o`, `prim_start_o`, `attr_valid_o`, `we_o`, `ew_data_o`, `tc_data_o` and `tile_addr_o` are all zero, whatever the other inputs are.
- R2: The opcode is `in_data[31:28]`: 4'h1 is a primitive, 4'h2 an attribute, 4'h8/4'h9/4'hA are sync types 0/1/2, and every other value is a no-op. A no-op is accepted and discarded without any strobe or stall.
- R3: Outside reset and stall, `in_ready` is high, except when the head opcode is a primitive and `ew_busy_i` is high. Attributes, syncs and no-ops are accepted regardless of `ew_busy_i`.
- R4: `prim_start_o` is high for exactly the one cycle after a primitive transfer. In that cycle `ew_data_o` carries bits [27:0] of that word; otherwise `ew_data_o` is zero.
- R5: `attr_valid_o` is high for exactly the one cycle after an attribute transfer. In that cycle `tc_data_o`=bits[15:0], `tile_addr_o`=bits[27:22] and `we_o` is one-hot at index bits[21:20]. Otherwise all four are zero.
- R6: `stall_o` rises in the cycle after a sync transfer, and the pending tag is the low two opcode bits (0, 1 or 2).
- R7: `stall_o` falls in the cycle after an edge at which `rel_valid` is high with `rel_tag` equal to the pending tag. A release with another tag, or any release while not stalled, has no effect.
- R8: While `stall_o` is high, `in_ready`, `prim_start_o` and `attr_valid_o` stay low.
- R9: Back-to-back syncs each produce their own stall and each need their own matching release, even when the second sync is accepted in the first cycle after a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Buffer head word is present |
| in_data | input | 32 | Buffer head word |
| in_ready | output | 1 | Head word is taken at this edge if valid |
| ew_busy_i | input | 1 | Edge walker busy; holds primitives |
| rel_valid | input | 1 | Sync release strobe |
| rel_tag | input | 2 | Sync type being released |
| stall_o | output | 1 | Sync stall state |
| prim_start_o | output | 1 | One-cycle primitive start pulse |
| ew_data_o | output | 28 | Primitive payload to edge walker |
| attr_valid_o | output | 1 | Attribute strobe |
| tc_data_o | output | 16 | Attribute data to texture side |
| tile_addr_o | output | 6 | Attribute tile address |
| we_o | output | 4 | One-hot attribute register write enable |

## Verification
The bench holds data and releases on the inputs during reset. A design that is not gated by reset would show a transfer or a stall leaking out. It presents a primitive while the edge walker is busy; a decoder that ignores the busy input would emit a start pulse for a primitive the walker cannot take. It sends releases with the wrong tag and releases outside any stall. A controller that ends the stall on any release would unfreeze early, and one that latches stray releases would fall through the next sync. It also issues a sync in the first cycle after a release, which exposes a stall state that takes an extra cycle to recover or that merges two syncs into one stall.

// File: rtl/cmdsync_pkg.sv
package cmdsync_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [1:0] {
    CLS_NOP  = 2'd0,
    CLS_PRIM = 2'd1,
    CLS_ATTR = 2'd2,
    CLS_SYNC = 2'd3
  } cmd_cls_e;

  localparam logic [OPC_W-1:0] OPC_PRIM  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_ATTR  = 4'h2;
  localparam logic [OPC_W-1:0] OPC_SYNC0 = 4'h8;
  localparam logic [OPC_W-1:0] OPC_SYNC1 = 4'h9;
  localparam logic [OPC_W-1:0] OPC_SYNC2 = 4'hA;

  function automatic cmd_cls_e classify(input logic [OPC_W-1:0] op);
    case (op)
      OPC_PRIM:                       return CLS_PRIM;
      OPC_ATTR:                       return CLS_ATTR;
      OPC_SYNC0, OPC_SYNC1, OPC_SYNC2: return CLS_SYNC;
      default:                        return CLS_NOP;
    endcase
  endfunction
endpackage

// File: rtl/cmdsync_decode.sv
module cmdsync_decode
  import cmdsync_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] head_word,
  output cmd_cls_e          head_cls,
  output logic [1:0]        head_tag
);
  logic [OPC_W-1:0] opc;

  always_comb begin
    opc      = head_word[WORD_W-1 -: OPC_W];
    head_cls = classify(opc);
    head_tag = opc[1:0];
  end
endmodule

// File: rtl/cmdsync_stall.sv
module cmdsync_stall #(
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_take,
  input  logic [TAG_W-1:0] sync_tag,
  input  logic             rel_valid,
  input  logic [TAG_W-1:0] rel_tag,
  output logic             stall
);
  logic [TAG_W-1:0] pend_tag_q;
  logic             stall_q;
  logic             rel_hit;

  assign rel_hit = stall_q && rel_valid && (rel_tag == pend_tag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q    <= 1'b0;
      pend_tag_q <= '0;
    end else if (sync_take) begin
      stall_q    <= 1'b1;
      pend_tag_q <= sync_tag;
    end else if (rel_hit) begin
      stall_q    <= 1'b0;
    end
  end

  assign stall = stall_q;
endmodule

// File: rtl/cmdsync_route.sv
module cmdsync_route
  import cmdsync_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int TC_W   = 16,
  parameter int TILE_W = 6,
  parameter int NWE    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  cmd_cls_e              take_cls,
  input  logic [WORD_W-1:0]     take_word,
  output logic                  prim_start,
  output logic [WORD_W-OPC_W-1:0] ew_data,
  output logic                  attr_valid,
  output logic [TC_W-1:0]       tc_data,
  output logic [TILE_W-1:0]     tile_addr,
  output logic [NWE-1:0]        we
);
  localparam int PAY_W    = WORD_W - OPC_W;
  localparam int SEL_W    = (NWE > 1) ? $clog2(NWE) : 1;
  localparam int TILE_LSB = PAY_W - TILE_W;
  localparam int SEL_LSB  = TILE_LSB - SEL_W;

  logic [PAY_W-1:0] pay_q;
  logic             prim_q;
  logic             attr_q;
  logic [SEL_W-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_q  <= '0;
      prim_q <= 1'b0;
      attr_q <= 1'b0;
    end else begin
      prim_q <= take && (take_cls == CLS_PRIM);
      attr_q <= take && (take_cls == CLS_ATTR);
      if (take) pay_q <= take_word[PAY_W-1:0];
    end
  end

  assign sel        = pay_q[SEL_LSB +: SEL_W];
  assign prim_start = prim_q;
  assign attr_valid = attr_q;
  assign ew_data    = prim_q ? pay_q : '0;
  assign tc_data    = attr_q ? pay_q[TC_W-1:0] : '0;
  assign tile_addr  = attr_q ? pay_q[TILE_LSB +: TILE_W] : '0;

  for (genvar i = 0; i < NWE; i++) begin : g_we
    assign we[i] = attr_q && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/cmdsync_ctrl.sv
module cmdsync_ctrl
  import cmdsync_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int TC_W   = 16,
  parameter int TILE_W = 6,
  parameter int NWE    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [WORD_W-1:0]       in_data,
  output logic                    in_ready,
  input  logic                    ew_busy_i,
  input  logic                    rel_valid,
  input  logic [1:0]              rel_tag,
  output logic                    stall_o,
  output logic                    prim_start_o,
  output logic [WORD_W-OPC_W-1:0] ew_data_o,
  output logic                    attr_valid_o,
  output logic [TC_W-1:0]         tc_data_o,
  output logic [TILE_W-1:0]       tile_addr_o,
  output logic [NWE-1:0]          we_o
);
  cmd_cls_e   head_cls;
  logic [1:0] head_tag;
  logic       take;

  cmdsync_decode #(.WORD_W(WORD_W)) u_dec (
    .head_word (in_data),
    .head_cls  (head_cls),
    .head_tag  (head_tag)
  );

  assign in_ready = rst_n && !stall_o && !(head_cls == CLS_PRIM && ew_busy_i);
  assign take     = in_valid && in_ready;

  cmdsync_stall #(.TAG_W(2)) u_stall (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_take (take && (head_cls == CLS_SYNC)),
    .sync_tag  (head_tag),
    .rel_valid (rel_valid),
    .rel_tag   (rel_tag),
    .stall     (stall_o)
  );

  cmdsync_route #(
    .WORD_W(WORD_W), .TC_W(TC_W), .TILE_W(TILE_W), .NWE(NWE)
  ) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .take_cls   (head_cls),
    .take_word  (in_data),
    .prim_start (prim_start_o),
    .ew_data    (ew_data_o),
    .attr_valid (attr_valid_o),
    .tc_data    (tc_data_o),
    .tile_addr  (tile_addr_o),
    .we         (we_o)
  );
endmodule

// File: rtl/cmdsync_ctrl_chk.sv
module cmdsync_ctrl_chk #(
  parameter int WORD_W = 32,
  parameter int NWE    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_data,
  input logic              in_ready,
  input logic              ew_busy_i,
  input logic              rel_valid,
  input logic [1:0]        rel_tag,
  input logic              stall_o,
  input logic              prim_start_o,
  input logic              attr_valid_o,
  input logic [NWE-1:0]    we_o
);
  logic [3:0] opc;
  logic       xfer;
  logic       is_sync;
  logic [1:0] chk_tag;

  assign opc     = in_data[WORD_W-1 -: 4];
  assign xfer    = in_valid && in_ready;
  assign is_sync = (opc == 4'h8) || (opc == 4'h9) || (opc == 4'hA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_tag <= '0;
    else if (xfer && is_sync) chk_tag <= opc[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!in_ready && !stall_o && !prim_start_o && !attr_valid_o && we_o == '0)
        else $error("R1 outputs active in reset");
    end
  end

  a_r3_busy_holds_prim: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == 4'h1 && ew_busy_i) |-> !in_ready);

  a_r4_prim_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && opc == 4'h1) |=> prim_start_o);

  a_r4_prim_cause: assert property (@(posedge clk) disable iff (!rst_n)
    prim_start_o |-> $past(xfer && opc == 4'h1));

  a_r5_attr_we: assert property (@(posedge clk) disable iff (!rst_n)
    attr_valid_o |-> ($countones(we_o) == 1));

  a_r5_we_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !attr_valid_o |-> (we_o == '0));

  a_r6_sync_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && is_sync) |=> stall_o);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !(rel_valid && rel_tag == chk_tag)) |=> stall_o);

  a_r7_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && rel_valid && rel_tag == chk_tag) |=> !stall_o);

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (!in_ready && !prim_start_o && !attr_valid_o));
endmodule

bind cmdsync_ctrl cmdsync_ctrl_chk #(.WORD_W(WORD_W), .NWE(NWE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .ew_busy_i(ew_busy_i), .rel_valid(rel_valid),
  .rel_tag(rel_tag), .stall_o(stall_o), .prim_start_o(prim_start_o),
  .attr_valid_o(attr_valid_o), .we_o(we_o)
);

// File: tb/cmdsync_ctrl_tb_top.sv
`timescale 1ns/1ps
module cmdsync_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        ew_busy_i = 1'b0;
  logic        rel_valid = 1'b0;
  logic [1:0]  rel_tag = '0;
  logic        stall_o, prim_start_o, attr_valid_o;
  logic [27:0] ew_data_o;
  logic [15:0] tc_data_o;
  logic [5:0]  tile_addr_o;
  logic [3:0]  we_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmdsync_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .ew_busy_i(ew_busy_i), .rel_valid(rel_valid),
    .rel_tag(rel_tag), .stall_o(stall_o), .prim_start_o(prim_start_o),
    .ew_data_o(ew_data_o), .attr_valid_o(attr_valid_o), .tc_data_o(tc_data_o),
    .tile_addr_o(tile_addr_o), .we_o(we_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive a word, take one edge, sample 2 ns after it.
  task automatic send(input logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    @(posedge clk); #2;
    in_valid = 1'b0;
    in_data  = '0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic release_tag(input logic [1:0] t);
    rel_valid = 1'b1;
    rel_tag   = t;
    @(posedge clk); #2;
    rel_valid = 1'b0;
  endtask

  function automatic logic [31:0] attr_word(input logic [5:0] tile, input logic [1:0] sel,
                                            input logic [15:0] d);
    return {4'h2, tile, sel, 4'h0, d};
  endfunction

  task automatic t_reset();
    in_valid = 1'b1; in_data = 32'h8000_0000; rel_valid = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R1 in_ready", {31'd0, in_ready}, 32'd0);
    check("R1 stall", {31'd0, stall_o}, 32'd0);
    check("R1 strobes", {prim_start_o, attr_valid_o, we_o}, 32'd0);
    check("R1 buses", {ew_data_o} | {tc_data_o} | {tile_addr_o}, 32'd0);
    in_valid = 1'b0; in_data = '0; rel_valid = 1'b0;
    rst_n = 1'b1;
    tick();
    check("R1 idle after reset", {29'd0, stall_o, prim_start_o, attr_valid_o}, 32'd0);
  endtask

  task automatic t_prim();
    send(32'h1ABC_DEF1);
    check("R4 start pulse", {31'd0, prim_start_o}, 32'd1);
    check("R4 ew_data", {4'd0, ew_data_o}, 32'h0ABC_DEF1);
    check("R4 no attr", {28'd0, attr_valid_o, we_o[2:0]}, 32'd0);
    tick();
    check("R4 single cycle", {31'd0, prim_start_o}, 32'd0);
    check("R4 ew_data cleared", {4'd0, ew_data_o}, 32'd0);
    send(32'h1000_0005);
    send(32'h1000_0006);
    check("R4 back to back prims", {3'd0, prim_start_o, ew_data_o}, 32'h1000_0006);
  endtask

  task automatic t_attr();
    send(attr_word(6'h2D, 2'd2, 16'h1234));
    check("R5 attr_valid", {31'd0, attr_valid_o}, 32'd1);
    check("R5 tc_data", {16'd0, tc_data_o}, 32'h1234);
    check("R5 tile_addr", {26'd0, tile_addr_o}, 32'h2D);
    check("R5 we onehot", {28'd0, we_o}, 32'h4);
    check("R5 no prim", {31'd0, prim_start_o}, 32'd0);
    send(attr_word(6'h01, 2'd3, 16'hBEEF));
    check("R5 we sel3", {12'd0, we_o, tc_data_o}, 32'h8BEEF);
    tick();
    check("R5 strobe cleared", {attr_valid_o, we_o, tc_data_o, tile_addr_o}, 32'd0);
  endtask

  task automatic t_nop();
    in_valid = 1'b1; in_data = 32'h5FFF_FFFF; #1;
    check("R2 nop accepted", {31'd0, in_ready}, 32'd1);
    send(32'h5FFF_FFFF);
    check("R2 nop silent", {26'd0, stall_o, prim_start_o, attr_valid_o, we_o[2:0]}, 32'd0);
    send(32'hB000_0000);
    check("R2 opcode B is nop", {31'd0, stall_o}, 32'd0);
  endtask

  task automatic t_busy();
    ew_busy_i = 1'b1;
    in_valid = 1'b1; in_data = 32'h1000_0077; #1;
    check("R3 prim held busy", {31'd0, in_ready}, 32'd0);
    tick();
    check("R3 no start while busy", {31'd0, prim_start_o}, 32'd0);
    in_data = attr_word(6'h3, 2'd0, 16'h00AA); #1;
    check("R3 attr passes busy", {31'd0, in_ready}, 32'd1);
    in_valid = 1'b0;
    ew_busy_i = 1'b0;
    send(32'h1000_0077);
    check("R3 prim after busy", {3'd0, prim_start_o, ew_data_o}, 32'h1000_0077);
  endtask

  task automatic t_sync(input logic [1:0] k);
    send({2'b10, k, 28'h0});
    check($sformatf("R6 stall type%0d", k), {31'd0, stall_o}, 32'd1);
    in_valid = 1'b1; in_data = attr_word(6'h9, 2'd1, 16'h5555); #1;
    check("R8 ready frozen", {31'd0, in_ready}, 32'd0);
    release_tag(k + 2'd1);
    check("R7 wrong tag ignored", {31'd0, stall_o}, 32'd1);
    check("R8 no attr in stall", {31'd0, attr_valid_o}, 32'd0);
    release_tag(k);
    check("R7 matching release", {31'd0, stall_o}, 32'd0);
    check("R8 nothing leaked", {31'd0, attr_valid_o}, 32'd0);
    send(attr_word(6'h9, 2'd1, 16'h5555));
    check("R7 resume attr", {15'd0, attr_valid_o, tc_data_o}, 32'h15555);
  endtask

  task automatic t_stray_release();
    release_tag(2'd0);
    check("R7 release idle ignored", {31'd0, stall_o}, 32'd0);
    send(32'h8000_0000);
    tick();
    check("R7 stray not latched", {31'd0, stall_o}, 32'd1);
    release_tag(2'd0);
    check("R7 stray case released", {31'd0, stall_o}, 32'd0);
  endtask

  task automatic t_back_to_back();
    send(32'h9000_0000);
    release_tag(2'd1);
    check("R9 first released", {31'd0, stall_o}, 32'd0);
    send(32'h9000_0000);
    check("R9 second stall", {31'd0, stall_o}, 32'd1);
    tick();
    check("R9 second holds", {31'd0, stall_o}, 32'd1);
    release_tag(2'd1);
    check("R9 second released", {31'd0, stall_o}, 32'd0);
    send(32'hA000_0000);
    release_tag(2'd2);
    send(32'h8000_0000);
    check("R9 mixed types stall", {31'd0, stall_o}, 32'd1);
    release_tag(2'd2);
    check("R9 old tag ignored", {31'd0, stall_o}, 32'd1);
    release_tag(2'd0);
    check("R9 mixed released", {31'd0, stall_o}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_prim();
    t_attr();
    t_nop();
    t_busy();
    for (int k = 0; k < 3; k++) t_sync(2'(k));
    t_stray_release();
    t_back_to_back();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule